// File: doc/BRIEF.md
# Two-Stage Sigma-Delta Output Combiner

This block merges the two digital streams of a cascaded pair of second-order sigma-delta loops into one signed word per modulator sample. Each accepted input pair carries a single-bit code from the first loop and a 13-level code from the second loop. The second-loop value goes through a second-order difference and is then multiplied by four, which the block does with a left shift because the digital interstage gain is a power of two. The first-loop value is delayed by two samples so that it lines up with the second path. Once the two paths line up, the first loop's quantization error cancels and only fourth-order-shaped error from the second loop is left. No multiplier is used.

Both edges of the block are valid/ready streams. An input pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result of that pair is registered and appears on `out_data` with `out_valid` high in the next cycle. If the consumer holds `out_ready` low while a result is pending, the result stays on the port unchanged and `in_ready` goes low. This back-pressure reaches the producer in the same cycle. Delay and difference history moves only when a pair is accepted. Idle cycles and stalled cycles therefore do not disturb the reconstruction.

Top module: `sdr_cascade_combine`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is low after that edge. All history is cleared to zero, so the delayed first-loop term and the earlier second-loop values add nothing to the first two results after reset.
- R2: `in_s1` = 1 stands for +1 and `in_s1` = 0 stands for -1.
- R3: `in_s2` is an unsigned 4-bit code. A code c in 0..12 stands for the integer c - 6.
- R4: The first-loop term in a result is the first-loop value accepted two samples earlier, counting accepted pairs only.
- R5: The second-loop term is v[n] - 2·v[n-1] + v[n-2], where v is the sequence of accepted second-loop values.
- R6: The second-loop term is scaled by 4 (a left shift by 2) and added to the first-loop term. `out_data` carries the sum as 8-bit two's complement.
- R7: Codes 13, 14 and 15 on `in_s2` are treated as code 12 (+6).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: The result of a pair accepted at one edge is on `out_data` with `out_valid` high after the next edge. With no new acceptance, `out_valid` falls after an edge where `out_ready` is high. Cycles without acceptance leave the history unchanged.
- R11: Results stay within -97..+97. The extremes are reached with second-loop codes 12, 0, 12 when the first-loop bit two samples before is 1 (+97), and with codes 0, 12, 0 when that bit is 0 (-97).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take an input pair |
| in_s1 | input | 1 | First-loop single-bit code |
| in_s2 | input | 4 | Second-loop 13-level code |
| out_valid | output | 1 | Combined result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Combined signed result |

## Verification
The bench builds the block with its defaults: two samples of first-loop delay, a second-order difference, a shift of two, 4-bit codes and an 8-bit result. These values make the ±97 extremes reachable. They also make it possible to drive the out-of-range codes 13 to 15, which exercise the clamp. Stimulus mixes gaps in `in_valid` with random stalls on `out_ready`. This shows that history moves only on accepted pairs, that a held result stays frozen, and that the difference chain still comes out right after long stalls.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  // single-bit first-loop code to its signed value (+1 / -1)
  function automatic logic signed [1:0] s1_to_value(input logic bit_in);
    return bit_in ? 2'sd1 : -2'sd1;
  endfunction
endpackage

// File: rtl/sdr_s1_delay.sv
module sdr_s1_delay #(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic signed [1:0] d_in,
  output logic signed [1:0] d_out
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign d_out = d_in;
    end else begin : g_chain
      logic signed [1:0] tap [DEPTH];
      for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        always_ff @(posedge clk) begin
          if (rst)     tap[k] <= '0;
          else if (en) tap[k] <= (k == 0) ? d_in : tap[(k == 0) ? 0 : k-1];
        end
      end
      assign d_out = tap[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdr_diff.sv
module sdr_diff #(
  parameter int IN_W  = 5,
  parameter int ORDER = 2,
  localparam int OUT_W = IN_W + ORDER
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  d_in,
  output logic signed [OUT_W-1:0] d_out
);
  logic signed [OUT_W-1:0] stage [ORDER+1];
  assign stage[0] = OUT_W'(d_in);

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic signed [OUT_W-1:0] prev;
      always_ff @(posedge clk) begin
        if (rst)     prev <= '0;
        else if (en) prev <= stage[k];
      end
      assign stage[k+1] = stage[k] - prev;
    end
  endgenerate

  assign d_out = stage[ORDER];
endmodule

// File: rtl/sdr_out_stage.sv
module sdr_out_stage #(
  parameter int SUM_W = 10,
  parameter int OUT_W = 8,
  parameter int BOUND = 97
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accept,
  input  logic signed [SUM_W-1:0] sum,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data
);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 <<< (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = SUM_W'(-(1 <<< (OUT_W-1)));

  logic signed [OUT_W-1:0] sat;
  always_comb begin
    if (sum > MAXV)      sat = MAXV[OUT_W-1:0];
    else if (sum < MINV) sat = MINV[OUT_W-1:0];
    else                 sat = sum[OUT_W-1:0];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= sat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> !out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_ready_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  assert_fill_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));
  assert_bound_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) <= BOUND && $signed(out_data) >= -BOUND));
endmodule

// File: rtl/sdr_cascade_combine.sv
module sdr_cascade_combine #(
  parameter int S2_W       = 4,
  parameter int S2_LEVELS  = 13,
  parameter int S1_DELAY   = 2,
  parameter int DIFF_ORDER = 2,
  parameter int GAIN_SHIFT = 2,
  parameter int OUT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_s1,
  input  logic [S2_W-1:0]  in_s2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  import sdr_pkg::*;

  localparam int S2_MID  = (S2_LEVELS - 1) / 2;
  localparam int VAL_W   = S2_W + 1;
  localparam int DIFF_W  = VAL_W + DIFF_ORDER;
  localparam int SHIFT_W = DIFF_W + GAIN_SHIFT;
  localparam int SUM_W   = SHIFT_W + 1;
  localparam int RAW_BND = 1 + ((S2_MID << DIFF_ORDER) << GAIN_SHIFT);
  localparam int SAT_BND = (1 << (OUT_W-1)) - 1;
  localparam int BOUND   = (RAW_BND < SAT_BND) ? RAW_BND : SAT_BND;
  localparam logic [S2_W-1:0] TOP_CODE = S2_W'(S2_LEVELS - 1);

  logic accept;
  assign accept = in_valid && in_ready;

  // second-loop code: clamp, then remove the mid-scale offset
  logic [S2_W-1:0]         code_c;
  logic signed [VAL_W-1:0] s2_val;
  assign code_c = (in_s2 > TOP_CODE) ? TOP_CODE : in_s2;
  assign s2_val = $signed({1'b0, code_c}) - VAL_W'(S2_MID);

  always_comb begin
    assert_clamp_R7: assert (s2_val <= VAL_W'(S2_MID) && s2_val >= -VAL_W'(S2_MID));
  end

  logic signed [1:0] s1_val, s1_late;
  assign s1_val = s1_to_value(in_s1);

  sdr_s1_delay #(.DEPTH(S1_DELAY)) u_s1_delay (
    .clk(clk), .rst(rst), .en(accept), .d_in(s1_val), .d_out(s1_late)
  );

  logic signed [DIFF_W-1:0] s2_diff;
  sdr_diff #(.IN_W(VAL_W), .ORDER(DIFF_ORDER)) u_diff (
    .clk(clk), .rst(rst), .en(accept), .d_in(s2_val), .d_out(s2_diff)
  );

  logic signed [SUM_W-1:0] scaled, sum;
  assign scaled = SUM_W'(s2_diff) <<< GAIN_SHIFT;
  assign sum    = scaled + SUM_W'(s1_late);

  logic signed [OUT_W-1:0] res;
  sdr_out_stage #(.SUM_W(SUM_W), .OUT_W(OUT_W), .BOUND(BOUND)) u_out (
    .clk(clk), .rst(rst), .accept(accept), .sum(sum),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res)
  );
  assign out_data = res;
endmodule

// File: tb/tb_sdr_cascade_combine.sv
module tb_sdr_cascade_combine;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_s1 = 0, out_ready = 1;
  logic [3:0] in_s2 = 4'd6;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  sdr_cascade_combine dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_s1(in_s1), .in_s2(in_s2), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1_reset";

  // behavioural reference
  int s1_hist[$];
  int s2_hist[$];
  bit mv = 0;
  int md = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mv = 0; md = 0;
      s1_hist = {0, 0};
      s2_hist = {0, 0};
    end else begin
      bit acc;
      acc = in_valid && (!mv || out_ready);
      if (acc) begin
        int v1, v2, d;
        v1 = in_s1 ? 1 : -1;                     // R2
        v2 = (in_s2 > 12 ? 12 : int'(in_s2)) - 6; // R3, R7
        d  = v2 - 2 * s2_hist[1] + s2_hist[0];    // R5
        md = s1_hist[0] + 4 * d;                  // R4, R6
        s1_hist.pop_front(); s1_hist.push_back(v1);
        s2_hist.pop_front(); s2_hist.push_back(v2);
        mv = 1;
      end else if (out_ready) mv = 0;
    end
    #2;
    if (!rst) begin
      total++;
      if (out_valid !== mv) begin
        bad++; $display("FAIL %s R10 out_valid=%0b expected %0b", phase, out_valid, mv);
      end
      total++;
      if (in_ready !== (!mv || out_ready)) begin
        bad++; $display("FAIL %s R9 in_ready=%0b expected %0b", phase, in_ready, !mv || out_ready);
      end
      if (mv) begin
        total++;
        if ($signed(out_data) != md) begin
          bad++; $display("FAIL %s out_data=%0d expected %0d", phase, $signed(out_data), md);
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit b, input logic [3:0] c);
    @(negedge clk);
    in_valid = 1; in_s1 = b; in_s2 = c;
    do @(posedge clk); while (!in_ready);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; out_ready = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    int seed;
    seed = 7;
    do_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R1: history zero, first result is 4*(+6)=24
    phase = "R1_first";
    send(1, 4'd12); #2;
    check("R1 first result", $signed(out_data), 24);
    idle();

    // R11 extremes
    do_reset(); phase = "R11_max";
    send(1, 4'd12); send(0, 4'd0); send(0, 4'd12); #2;
    check("R11 max", $signed(out_data), 97);
    send(0, 4'd0); send(1, 4'd12); send(1, 4'd0); #2;
    check("R11 min", $signed(out_data), -97);
    idle();

    // R2..R6 random streams, no stall
    phase = "R5_stream";
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      send(seed[16], 4'((seed >>> 20) % 13));
    end
    idle();

    // R7 out-of-range codes
    phase = "R7_clamp";
    for (int i = 0; i < 60; i++) begin
      seed = seed * 1103515245 + 12345;
      send(seed[17], 4'(10 + ((seed >>> 19) & 5)));
    end
    idle();

    // R8/R10 gaps and stalls
    phase = "R8_stall";
    for (int i = 0; i < 1500; i++) begin
      seed = seed * 1103515245 + 12345;
      @(negedge clk);
      in_valid  = seed[21] | seed[22];
      in_s1     = seed[15];
      in_s2     = 4'((seed >>> 24) & 15);
      out_ready = seed[18] & seed[19] ? 1'b0 : seed[23];
    end
    @(negedge clk); in_valid = 0; out_ready = 0;
    repeat (5) @(negedge clk);
    out_ready = 1;
    repeat (4) @(negedge clk);
    finish_run();
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule